// File: doc/BRIEF.md
# Ethernet Link Status LED Driver

This block turns the Ethernet link state into three active-low LED enables: one for duplex, one for link and activity, and one for line speed. The duplex and speed LEDs follow the link status inputs directly. The link LED stays lit while a link is up. When traffic is seen, it blinks off for a fixed window and then stays on for at least the same window before it can blink again.

Transmit and receive activity arrive as single-cycle pulses. The blink window length is a parameter counted in clock cycles. Its default is 80 ms at a 25 MHz clock. Any pulse that arrives while a blink is in progress is remembered, so a busy link gives a steady off/on rhythm instead of a pattern that depends on when each packet arrived. A drop of the link cancels the blink at once.

Top module: `link_led_drv`

## Requirements
- R1: `fdx_led_n` is 0 exactly when `link_up` and `duplex_full` are both 1, and 1 otherwise.
- R2: With the link up and no activity pending, `lnk_led_n` is 0.
- R3: A `tx_activity` or `rx_activity` pulse sampled at a rising clock edge while the link is up and no blink is in progress drives `lnk_led_n` to 1 from the next cycle, for exactly `WINDOW_CYCLES` cycles.
- R4: After an off window ends, `lnk_led_n` is 0 for at least `WINDOW_CYCLES` cycles.
- R5: Activity sampled during an off window or an on window is held. The next off window then starts in the cycle right after the on window's `WINDOW_CYCLES` cycles end.
- R6: If no activity is seen during either window, the link LED stays at 0 after the on window until new activity arrives.
- R7: While `link_up` is 0, `lnk_led_n` is 1 in the same cycle, activity is ignored and any pending blink is discarded. When the link returns, the LED is 0 at once.
- R8: `spd_led_n` is 1 whenever `isolate` is 1. Otherwise it is 0 when `speed_100` or `autoneg_active` is 1, and 1 in 10 Mb/s operation with no auto-negotiation running.
- R9: While `rst_n` is 0, the blink state is cleared. Right after reset with the link down, all three LEDs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Valid link present |
| duplex_full | input | 1 | Link runs full duplex |
| speed_100 | input | 1 | Link runs at 100 Mb/s |
| autoneg_active | input | 1 | Auto-negotiation in progress |
| isolate | input | 1 | Line isolated |
| tx_activity | input | 1 | One-cycle transmit activity pulse |
| rx_activity | input | 1 | One-cycle receive activity pulse |
| fdx_led_n | output | 1 | Duplex LED enable, 0 = lit |
| lnk_led_n | output | 1 | Link/activity LED enable, 0 = lit |
| spd_led_n | output | 1 | Speed LED enable, 0 = lit |

## Verification
The bench aims pulses at the first and last cycle of each window. A design with an off-by-one counter shows a window that is one cycle too short or too long. A design that samples activity only in one window, or drops it at the window boundary, fails to start the following blink. The bench also drops the link in the middle of a blink and pulses activity while the link is down. A design that keeps its blink state across the drop would blink again after the link returns. The bench also applies `isolate` together with `speed_100` and with auto-negotiation, which catches a speed LED that gives those inputs priority over isolation.

// File: rtl/link_led_drv.sv
module link_led_drv #(
  parameter int WINDOW_CYCLES = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic duplex_full,
  input  logic speed_100,
  input  logic autoneg_active,
  input  logic isolate,
  input  logic tx_activity,
  input  logic rx_activity,
  output logic fdx_led_n,
  output logic lnk_led_n,
  output logic spd_led_n
);
  localparam int CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DARK, ST_LIT} blink_t;

  blink_t        state;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          act;
  logic          wend;

  assign act  = tx_activity | rx_activity;
  assign wend = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !link_up) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pend  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (act) state <= ST_DARK;
        end
        ST_DARK: begin
          pend <= pend | act;
          if (wend) begin
            state <= ST_LIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LIT: begin
          if (wend) begin
            cnt   <= '0;
            pend  <= 1'b0;
            state <= (pend | act) ? ST_DARK : ST_IDLE;
          end else begin
            cnt  <= cnt + 1'b1;
            pend <= pend | act;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fdx_led_n = ~(link_up & duplex_full);
  assign lnk_led_n = ~link_up | (state == ST_DARK);
  assign spd_led_n = isolate | ~(speed_100 | autoneg_active);
endmodule

// File: rtl/link_led_drv_chk.sv
module link_led_drv_chk #(
  parameter int WINDOW_CYCLES = 2_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic link_up,
  input logic lnk_led_n
);
  localparam int RW = $clog2(WINDOW_CYCLES + 2) + 1;
  localparam logic [RW-1:0] WIN = RW'(WINDOW_CYCLES);

  logic [RW-1:0] dark_run;
  logic [RW-1:0] lit_run;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dark_run <= '0;
      lit_run  <= '0;
      armed    <= 1'b0;
    end else begin
      dark_run <= (link_up && lnk_led_n) ? dark_run + 1'b1 : '0;
      if (!link_up || lnk_led_n) lit_run <= '0;
      else if (lit_run < WIN) lit_run <= lit_run + 1'b1;
      if (!link_up || lnk_led_n) armed <= 1'b0;
      else if (dark_run != '0) armed <= 1'b1;
    end
  end

  AST_DARK_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && lnk_led_n) |-> dark_run < WIN); // R3

  AST_DARK_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lnk_led_n) && link_up && $past(link_up)) |-> dark_run == WIN); // R3

  AST_LIT_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lnk_led_n) && link_up && armed) |-> lit_run >= WIN); // R4

  AST_RELINK_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !$past(link_up)) |-> !lnk_led_n); // R7
endmodule

bind link_led_drv link_led_drv_chk #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_up(link_up), .lnk_led_n(lnk_led_n)
);

// File: tb/link_led_drv_tb.sv
module link_led_drv_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 0, duplex_full = 0, speed_100 = 0, autoneg_active = 0, isolate = 0;
  logic tx_activity = 0, rx_activity = 0;
  logic fdx_led_n, lnk_led_n, spd_led_n;

  int n_tests = 0;
  int n_fail = 0;
  int dark_left = 0, lit_left = 0;
  bit held = 0;

  always #10 clk = ~clk;

  link_led_drv #(.WINDOW_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .duplex_full(duplex_full),
    .speed_100(speed_100), .autoneg_active(autoneg_active), .isolate(isolate),
    .tx_activity(tx_activity), .rx_activity(rx_activity),
    .fdx_led_n(fdx_led_n), .lnk_led_n(lnk_led_n), .spd_led_n(spd_led_n)
  );

  always @(posedge clk) begin
    automatic bit a = tx_activity | rx_activity;
    if (!rst_n || !link_up) begin
      dark_left = 0; lit_left = 0; held = 0;
    end else if (dark_left > 0) begin
      held |= a;
      dark_left--;
      if (dark_left == 0) lit_left = W;
    end else if (lit_left > 0) begin
      held |= a;
      lit_left--;
      if (lit_left == 0 && held) begin dark_left = W; held = 0; end
    end else if (a) begin
      dark_left = W;
    end
  end

  function automatic logic exp_fdx();
    return !(link_up && duplex_full);
  endfunction
  function automatic logic exp_spd();
    return isolate || !(speed_100 || autoneg_active);
  endfunction
  function automatic logic exp_lnk();
    return !link_up || (dark_left > 0);
  endfunction

  task automatic check(input string tag, input logic act_v, input logic exp_v, input string what);
    n_tests++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act_v, exp_v, $time);
    end
  endtask

  task automatic check_all(input string lnk_tag);
    #2;
    check("R1", fdx_led_n, exp_fdx(), "fdx_led_n");
    check("R8", spd_led_n, exp_spd(), "spd_led_n");
    check(lnk_tag, lnk_led_n, exp_lnk(), "lnk_led_n");
  endtask

  task automatic cyc(input string tag, input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
    end
  endtask

  task automatic pulse(input string tag, input bit use_rx);
    if (use_rx) rx_activity = 1; else tx_activity = 1;
    cyc(tag);
    tx_activity = 0; rx_activity = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    link_up = 1;
    tx_activity = 1;
    repeat (3) @(negedge clk);
    tx_activity = 0; link_up = 0;
    #2;
    check("R9", lnk_led_n, 1'b1, "lnk_led_n in reset");
    rst_n = 1;
    cyc("R9", 2);
    check("R9", fdx_led_n, 1'b1, "fdx_led_n after reset");
    check("R9", spd_led_n, 1'b1, "spd_led_n after reset");

    for (int v = 0; v < 32; v++) begin
      {link_up, duplex_full, speed_100, autoneg_active, isolate} = 5'(v);
      #2;
      check_all("R2");
      cyc("R2");
    end
    link_up = 1; duplex_full = 1; speed_100 = 1; autoneg_active = 0; isolate = 0;
    cyc("R2", 3);

    pulse("R3", 0);
    cyc("R3", W - 1);
    cyc("R4", W);
    cyc("R6", 2 * W);

    pulse("R5", 1);
    cyc("R5", W - 1);
    pulse("R5", 0);
    cyc("R5", W - 1);
    pulse("R5", 1);
    cyc("R5", 3 * W);

    pulse("R5", 0);
    cyc("R5", W);
    cyc("R5", W - 2);
    pulse("R5", 0);
    cyc("R5", 3 * W);

    pulse("R7", 0);
    cyc("R7", 3);
    link_up = 0;
    #2;
    check("R7", lnk_led_n, 1'b1, "lnk_led_n at link drop");
    cyc("R7", 2);
    pulse("R7", 1);
    cyc("R7", 2);
    link_up = 1;
    #2;
    check("R7", lnk_led_n, 1'b0, "lnk_led_n at link return");
    cyc("R7", 3 * W);

    for (int i = 0; i < 4000; i++) begin
      automatic int r = int'($urandom_range(0, 99));
      tx_activity = (r < 6);
      rx_activity = (r >= 94);
      if ($urandom_range(0, 199) == 0) link_up = ~link_up;
      if ($urandom_range(0, 49) == 0) begin
        duplex_full = 1'($urandom); speed_100 = 1'($urandom);
        autoneg_active = 1'($urandom); isolate = 1'($urandom);
      end
      cyc("R5");
    end
    tx_activity = 0; rx_activity = 0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule